// File: doc/BRIEF.md
# Cascadable Dual Counter with Byte Readout

Two 16-bit binary up-counters, A and B, advance on their own count strobes. Both strobes are modelled as single-cycle enables of one system clock. Counter A counts on every strobe. Counter B counts only while its active-low enable is low. One active-low clear zeroes both counters.

A common snapshot strobe copies both counters at once into a pair of holding registers. Software never sees the live counters. It reads the holding registers one byte at a time through an 8-bit port. The byte is chosen by four active-low select lines, and the port floats when no line is low.

Counter A has an active-low carry that is low while A is all ones. Feeding that carry into B's enable, with both strobes tied together, turns the pair into one 32-bit counter.

The select path is a small combinational decision machine. It has three named outcomes:
- RD_IDLE: no select line is low. The port is released.
- RD_DRIVE: exactly one line is low. The chosen byte is driven.
- RD_CLASH: two or more lines are low. The error flag is raised and the port is released.

The machine moves between these outcomes as soon as the select lines change, with no clock involved. RD_IDLE goes to RD_DRIVE when one line falls. RD_DRIVE goes to RD_CLASH when a second line falls. Any outcome returns to RD_IDLE when all lines rise.

Top module: `dual_count_readout`

## Requirements
- R1: After reset both counters and both holding registers are zero, and `carry_n` is high.
- R2: At a clock edge where `clr_n` is high and `a_tick` is high, counter A increments by one. It wraps from FFFF to 0000.
- R3: Counter B increments at an edge only when `b_tick` is high, `b_en_n` is low and `clr_n` is high. Otherwise B keeps its value.
- R4: At an edge where `clr_n` is low, both counters become zero whatever the strobes are.
- R5: At an edge where `snap_tick` is high, both holding registers load the counter values from before that edge. An increment at the same edge is not captured.
- R6: When exactly one select line is low, `dout_oe` is 1 and `dout` carries one byte. Line bit 0 selects A[7:0], bit 1 selects A[15:8], bit 2 selects B[7:0] and bit 3 selects B[15:8], all taken from the holding registers.
- R7: When all select lines are high, `dout_oe` is 0, `sel_err` is 0 and `dout` is released.
- R8: When two or more select lines are low, `sel_err` is 1, `dout_oe` is 0 and `dout` is released.
- R9: `carry_n` is low exactly when counter A is FFFF and `clr_n` is high.
- R10: With both strobes driven together and `carry_n` fed to `b_en_n`, the 32-bit value {B,A} steps from 0x0000FFFF to 0x00010000 in one edge.
- R11: Without a snapshot strobe the byte read back does not change while the counters keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear of both counters |
| a_tick | input | 1 | Count strobe of counter A |
| b_tick | input | 1 | Count strobe of counter B |
| b_en_n | input | 1 | Active-low count enable of counter B |
| snap_tick | input | 1 | Snapshot strobe loading both holding registers |
| sel_n | input | 4 | Active-low byte select, one line per byte |
| carry_n | output | 1 | Active-low carry of counter A |
| dout | output | 8 | Selected byte, released when not driven |
| dout_oe | output | 1 | High while `dout` is driven |
| sel_err | output | 1 | High while more than one select line is low |

## Verification
The bench builds the block with its default 16-bit counters and 8-bit port. At that size a full walk of counter A to FFFF takes 65,535 strobes, which is within the run time. This brings the true 32-bit rollover into reach, together with the carry sitting low for exactly the all-ones value. With four select lines, the bench can also cover every legal code and several clashing codes.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_DRIVE = 2'd1,
        RD_CLASH = 2'd2
    } rd_mode_e;

endpackage

// File: rtl/dcnt_counter.sv
module dcnt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         tick,
    input  logic         en_n,
    output logic [W-1:0] q,
    output logic         full
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!clr_n) begin
            q <= '0;
        end else if (tick && !en_n) begin
            q <= q + ONE;
        end
    end

    assign full = (q == ALL1);

endmodule

// File: rtl/dcnt_snap.sv
module dcnt_snap #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d_a,
    input  logic [W-1:0] d_b,
    output logic [W-1:0] q_a,
    output logic [W-1:0] q_b
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_a <= '0;
            q_b <= '0;
        end else if (load) begin
            q_a <= d_a;
            q_b <= d_b;
        end
    end

endmodule

// File: rtl/dcnt_byte_sel.sv
module dcnt_byte_sel
    import dcnt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [CNT_W-1:0]             hold_a,
    input  logic [CNT_W-1:0]             hold_b,
    input  logic [2*(CNT_W/BYTE_W)-1:0]  sel_n,
    output logic [BYTE_W-1:0]            data,
    output logic                         oe,
    output logic                         err,
    output rd_mode_e                     mode
);

    localparam int LANES = CNT_W / BYTE_W;
    localparam int NSEL  = 2 * LANES;
    localparam int CW    = $clog2(NSEL + 1);

    logic [2*CNT_W-1:0]  pool;
    logic [CW-1:0]       n_low;
    logic [BYTE_W-1:0]   lane_bus [NSEL];

    assign pool = {hold_b, hold_a};

    always_comb begin
        n_low = '0;
        for (int i = 0; i < NSEL; i++) begin
            if (!sel_n[i]) n_low = n_low + CW'(1);
        end
    end

    always_comb begin
        unique case (n_low)
            CW'(0):  mode = RD_IDLE;
            CW'(1):  mode = RD_DRIVE;
            default: mode = RD_CLASH;
        endcase
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_lane
        assign lane_bus[g] = pool[g*BYTE_W +: BYTE_W] & {BYTE_W{~sel_n[g]}};
    end

    always_comb begin
        data = '0;
        oe   = 1'b0;
        err  = 1'b0;
        unique case (mode)
            RD_IDLE: begin
                oe = 1'b0;
            end
            RD_DRIVE: begin
                oe = 1'b1;
                for (int i = 0; i < NSEL; i++) data = data | lane_bus[i];
            end
            RD_CLASH: begin
                err = 1'b1;
            end
            default: begin
                err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dual_count_readout.sv
module dual_count_readout
    import dcnt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr_n,
    input  logic                            a_tick,
    input  logic                            b_tick,
    input  logic                            b_en_n,
    input  logic                            snap_tick,
    input  logic [2*(CNT_W/BYTE_W)-1:0]     sel_n,
    output logic                            carry_n,
    output logic [BYTE_W-1:0]               dout,
    output logic                            dout_oe,
    output logic                            sel_err
);

    logic [CNT_W-1:0]  cnt_a;
    logic [CNT_W-1:0]  cnt_b;
    logic [CNT_W-1:0]  hold_a;
    logic [CNT_W-1:0]  hold_b;
    logic              full_a;
    logic              full_b;
    logic [BYTE_W-1:0] sel_data;
    rd_mode_e          rd_mode;

    dcnt_counter #(.W(CNT_W)) u_cnt_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .tick  (a_tick),
        .en_n  (1'b0),
        .q     (cnt_a),
        .full  (full_a)
    );

    dcnt_counter #(.W(CNT_W)) u_cnt_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .tick  (b_tick),
        .en_n  (b_en_n),
        .q     (cnt_b),
        .full  (full_b)
    );

    dcnt_snap #(.W(CNT_W)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (snap_tick),
        .d_a   (cnt_a),
        .d_b   (cnt_b),
        .q_a   (hold_a),
        .q_b   (hold_b)
    );

    dcnt_byte_sel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_sel (
        .hold_a (hold_a),
        .hold_b (hold_b),
        .sel_n  (sel_n),
        .data   (sel_data),
        .oe     (dout_oe),
        .err    (sel_err),
        .mode   (rd_mode)
    );

    assign carry_n = ~(full_a & clr_n);
    assign dout    = dout_oe ? sel_data : {BYTE_W{1'bz}};

endmodule

// File: rtl/dual_count_readout_chk.sv
module dual_count_readout_chk #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         clr_n,
    input logic                         a_tick,
    input logic                         b_tick,
    input logic                         b_en_n,
    input logic                         snap_tick,
    input logic [2*(CNT_W/BYTE_W)-1:0]  sel_n,
    input logic                         carry_n,
    input logic                         dout_oe,
    input logic                         sel_err,
    input logic [CNT_W-1:0]             cnt_a,
    input logic [CNT_W-1:0]             cnt_b,
    input logic [CNT_W-1:0]             hold_a,
    input logic [CNT_W-1:0]             hold_b
);

    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    AST_A_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && a_tick) |=> (cnt_a == CNT_W'($past(cnt_a) + 1'b1))); // R2

    AST_B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && (!b_tick || b_en_n)) |=> $stable(cnt_b)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (cnt_a == '0 && cnt_b == '0)); // R4

    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        snap_tick |=> (hold_a == $past(cnt_a) && hold_b == $past(cnt_b))); // R5

    AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_tick |=> ($stable(hold_a) && $stable(hold_b))); // R11

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> ($countones(~sel_n) == 1)); // R6

    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~sel_n) > 1) |-> (sel_err && !dout_oe)); // R8

    AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (cnt_a == ALL1 && clr_n)); // R9

endmodule

bind dual_count_readout dual_count_readout_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .a_tick    (a_tick),
    .b_tick    (b_tick),
    .b_en_n    (b_en_n),
    .snap_tick (snap_tick),
    .sel_n     (sel_n),
    .carry_n   (carry_n),
    .dout_oe   (dout_oe),
    .sel_err   (sel_err),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .hold_a    (hold_a),
    .hold_b    (hold_b)
);

// File: tb/dual_count_readout_bench.sv
module dual_count_readout_bench;

    typedef struct {
        logic [7:0] data;
        logic       oe;
        logic       err;
        string      tag;
    } rd_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       a_tick = 1'b0;
    logic       b_tick = 1'b0;
    logic       b_en_drv = 1'b1;
    logic       cascade = 1'b0;
    logic       snap_tick = 1'b0;
    logic [3:0] sel_n = 4'hF;
    logic       carry_n;
    logic [7:0] dout;
    logic       dout_oe;
    logic       sel_err;
    logic       b_en_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic [15:0] exp_a = '0, exp_b = '0, exp_ha = '0, exp_hb = '0;
    rd_item_t    sb_q [$];

    assign b_en_n = cascade ? carry_n : b_en_drv;

    always #4 clk = ~clk;

    dual_count_readout u_dual_count_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .a_tick    (a_tick),
        .b_tick    (b_tick),
        .b_en_n    (b_en_n),
        .snap_tick (snap_tick),
        .sel_n     (sel_n),
        .carry_n   (carry_n),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .sel_err   (sel_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares the readout with queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(dout_oe == it.oe && sel_err == it.err && (!it.oe || dout == it.data),
                      it.tag, {22'd0, sel_err, dout_oe, dout}, {22'd0, it.err, it.oe, it.data});
            end
        end
    end

    // One clock edge; the bench model follows the requirements.
    task automatic step();
        logic [15:0] pa, pb;
        logic        ben;
        pa  = exp_a;
        pb  = exp_b;
        ben = cascade ? !(pa == 16'hFFFF && clr_n) : b_en_drv;
        @(posedge clk);
        #1;
        if (!clr_n) begin
            exp_a = '0;
            exp_b = '0;
        end else begin
            if (a_tick) exp_a = pa + 16'd1;
            if (b_tick && !ben) exp_b = pb + 16'd1;
        end
        if (snap_tick) begin
            exp_ha = pa;
            exp_hb = pb;
        end
    endtask

    task automatic read_sel(input logic [3:0] s, input string tag);
        rd_item_t it;
        logic [31:0] pool;
        int n;
        pool = {exp_hb, exp_ha};
        n = 0;
        for (int i = 0; i < 4; i++) if (!s[i]) n++;
        it.tag  = tag;
        it.oe   = (n == 1);
        it.err  = (n > 1);
        it.data = 8'h00;
        for (int i = 0; i < 4; i++) if (n == 1 && !s[i]) it.data = pool[i*8 +: 8];
        step();
        sel_n = s;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        read_sel(4'b1110, {tag, " A lo"});
        read_sel(4'b1101, {tag, " A hi"});
        read_sel(4'b1011, {tag, " B lo"});
        read_sel(4'b0111, {tag, " B hi"});
        read_sel(4'b1111, {tag, " idle"});
    endtask

    task automatic snap();
        snap_tick = 1'b1;
        step();
        snap_tick = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(carry_n == 1'b1, "R1 carry after reset", {31'd0, carry_n}, 32'd1);
        read_all("R1 reset hold");
        read_sel(4'b1111, "R7 idle released");

        // R2 / R3: independent counting with gated B
        a_tick = 1'b1; b_tick = 1'b1; b_en_drv = 1'b0;
        repeat (3) step();
        b_en_drv = 1'b1;
        repeat (2) step();
        a_tick = 1'b0; b_tick = 1'b0;
        snap();
        read_all("R2 R3 counts");

        // R11: counting without snapshot leaves readout unchanged
        a_tick = 1'b1;
        repeat (4) step();
        a_tick = 1'b0;
        read_sel(4'b1110, "R11 stale A lo");

        // R5: snapshot and increment on the same edge
        a_tick = 1'b1; b_tick = 1'b1; b_en_drv = 1'b0;
        snap();
        a_tick = 1'b0; b_tick = 1'b0; b_en_drv = 1'b1;
        read_all("R5 pre-edge value");
        snap();
        read_sel(4'b1110, "R5 post-edge A lo");

        // R4: clear overrides strobes
        clr_n = 1'b0; a_tick = 1'b1; b_tick = 1'b1; b_en_drv = 1'b0;
        step();
        @(negedge clk);
        check(carry_n == 1'b1, "R4 carry high in clear", {31'd0, carry_n}, 32'd1);
        clr_n = 1'b1; a_tick = 1'b0; b_tick = 1'b0; b_en_drv = 1'b1;
        snap();
        read_all("R4 cleared");

        // R8: clashing selects
        read_sel(4'b1100, "R8 clash A pair");
        read_sel(4'b0000, "R8 clash all");
        read_sel(4'b0110, "R8 clash mixed");
        read_sel(4'b1111, "R7 back to idle");

        // R9 / R10: cascaded 32-bit count
        cascade = 1'b1; a_tick = 1'b1; b_tick = 1'b1;
        for (int i = 0; i < 65535; i++) step();
        a_tick = 1'b0; b_tick = 1'b0;
        @(negedge clk);
        check(carry_n == 1'b0, "R9 carry at FFFF", {31'd0, carry_n}, 32'd0);
        snap();
        read_all("R10 before rollover");
        a_tick = 1'b1; b_tick = 1'b1;
        step();
        a_tick = 1'b0; b_tick = 1'b0;
        @(negedge clk);
        check(carry_n == 1'b1, "R9 carry after wrap", {31'd0, carry_n}, 32'd1);
        snap();
        check({exp_hb, exp_ha} == 32'h0001_0000, "R10 model rollover", {exp_hb, exp_ha}, 32'h0001_0000);
        read_all("R10 after rollover");

        repeat (2) step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule